// File: doc/BRIEF.md
# Line Holding Latch with Charge-Share Sequencing

This block sits between a column driver's line buffer and its per-column output stages. When the external load strobe goes from high to low, the block copies the gray code of every column from the buffer into a holding register. It also captures the polarity select and the charge-share length with that same copy. Each column then enters a charge-share phase for the captured number of clock cycles. During that phase every column is tied to a shared neutral node. When the phase ends, every column drives its held code.

The polarity select and the column's position together decide whether a column uses the high-side or the low-side reference set. Neighbouring columns always take opposite sets. The controller chooses dot, column or N-line inversion by how it toggles the polarity select from line to line.

The strobe has no timing relation to the local clock, so a synchronizer and an edge detector inside the block handle it. The buffer contents must stay stable until the copy, which comes at most three clock edges after the strobe falls. A new strobe that arrives during a charge-share interval restarts the interval with the newly copied line.

Top module: `lcs_line_latch`

## Requirements
- R1: After reset every column phase reads 2'b00 (idle) and every held code reads zero. The reference select reads 1 on columns with an odd 0-based index and 0 on the others, which is the polarity-low pattern.
- R2: A high-to-low transition of `ld_strobe` copies `line_codes` into `col_codes` at the third rising clock edge at which the strobe is seen low. The first two of those edges leave `col_codes` unchanged.
- R3: Column phase is encoded as 2'b00 idle, 2'b01 charge-share and 2'b10 drive. After a copy with a share length of N (N > 0), the phase reads 2'b01 for exactly N clock cycles and then 2'b10 until the next copy. It never returns to 2'b00.
- R4: A copy with a share length of zero puts every column directly into drive (2'b10) at the copy edge.
- R5: Column i (0-based; lane i carries bits [i*GRAY_W +: GRAY_W] of the code buses and bits [2i +: 2] of `col_phase`) gets `col_hi_ref[i]` = the captured polarity XOR (i odd). 1 selects the high-side reference set, so adjacent columns always differ.
- R6: Polarity is captured only at the copy edge. Changes to `pol_sel` between copies leave `col_hi_ref` unchanged.
- R7: Changes to `line_codes` after a copy leave `col_codes` unchanged until the next copy.
- R8: A copy made while a charge-share interval is still counting restarts the interval with the new length and the new codes.
- R9: A low-to-high transition of `ld_strobe` causes no copy and does not change the phase.
- R10: The share length is captured at the copy edge. Changes to `share_len` during an interval do not change how long that interval lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_strobe | input | 1 | Asynchronous line load strobe; the falling edge triggers a copy |
| pol_sel | input | 1 | Polarity select for the next line |
| line_codes | input | NUM_COLS*GRAY_W | Buffered gray codes, column 0 in the low bits |
| share_len | input | LEN_W | Charge-share length in clock cycles |
| col_codes | output | NUM_COLS*GRAY_W | Held gray code per column |
| col_hi_ref | output | NUM_COLS | Per-column reference select, 1 = high-side set |
| col_phase | output | 2*NUM_COLS | Per-column phase: 00 idle, 01 share, 10 drive |

## Verification
A corrupted synchronizer stage shows up at once as a copy that comes one edge early or late, and the per-cycle comparison of `col_codes` catches it. An off-by-one in the share counter changes how many cycles read 2'b01, so the error appears at the end of the first interval. A lane that latches polarity with the wrong parity breaks the alternation of `col_hi_ref` right after reset. Because a restart loads fresh data and a fresh count, a timer that ignores a copy during share is exposed within the same line.

// File: rtl/lcs_pkg.sv
// Shared types for the line latch and charge-share sequencer.
package lcs_pkg;

    // Output phase of a column; the encoding is visible at the ports.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_SHARE = 2'b01,
        PH_DRIVE = 2'b10
    } phase_t;

endpackage

// File: rtl/lcs_strobe_sync.sv
// Brings the asynchronous load strobe into the clock domain and flags its
// falling edge. Assumes the strobe idles high and stays low for at least
// two clock periods. The copy pulse is high for one cycle, so the holding
// registers load at the third edge that sees the strobe low.
module lcs_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic copy_pulse
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    // chain[0] is the first flop; chain[CHAIN_W-1] holds the previous sample.
    logic [CHAIN_W-1:0] chain;

    // Shift the strobe through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[CHAIN_W-2:0], strobe_async};
        end
    end

    // Falling edge: the older sample is high and the newer is low.
    assign copy_pulse = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];

endmodule

// File: rtl/lcs_share_timer.sv
// Sequences the common phase after each copy: charge-share for the
// captured number of cycles, then drive. Assumes copy_pulse lasts one
// cycle. A copy during share reloads the count and restarts the interval.
module lcs_share_timer
    import lcs_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             copy_pulse,
    input  logic [LEN_W-1:0] share_len,
    output phase_t           phase
);

    localparam logic [LEN_W-1:0] LAST_TICK = LEN_W'(1);

    logic [LEN_W-1:0] remain;

    // Load the count on a copy; count down while sharing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            phase  <= PH_IDLE;
        end else if (copy_pulse) begin
            remain <= share_len;
            phase  <= (share_len == '0) ? PH_DRIVE : PH_SHARE;
        end else if (phase == PH_SHARE) begin
            remain <= remain - LAST_TICK;
            if (remain == LAST_TICK) begin
                phase <= PH_DRIVE;
            end
        end
    end

endmodule

// File: rtl/lcs_column_lane.sv
// One column: holds its gray code and its reference select, captured on
// the copy pulse, and presents the shared phase. ODD_COL marks an odd
// 0-based index, which inverts the polarity-to-reference mapping.
module lcs_column_lane
    import lcs_pkg::*;
#(
    parameter int GRAY_W  = 6,
    parameter bit ODD_COL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              copy_pulse,
    input  logic              pol_sel,
    input  logic [GRAY_W-1:0] code_in,
    input  phase_t            phase_in,
    output logic [GRAY_W-1:0] code_out,
    output logic              hi_ref,
    output logic [1:0]        phase_out
);

    // Capture code and reference select together on a copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            hi_ref   <= ODD_COL;
        end else if (copy_pulse) begin
            code_out <= code_in;
            hi_ref   <= pol_sel ^ ODD_COL;
        end
    end

    // Present the common phase on this column's pins.
    assign phase_out = phase_in;

endmodule

// File: rtl/lcs_line_latch.sv
// Top of the line latch and charge-share sequencer. Assumes line_codes
// stays stable from the falling edge of ld_strobe until the copy, and
// that pol_sel and share_len are set up by then as well.
module lcs_line_latch
    import lcs_pkg::*;
#(
    parameter int NUM_COLS    = 384,
    parameter int GRAY_W      = 6,
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_strobe,
    input  logic                       pol_sel,
    input  logic [NUM_COLS*GRAY_W-1:0] line_codes,
    input  logic [LEN_W-1:0]           share_len,
    output logic [NUM_COLS*GRAY_W-1:0] col_codes,
    output logic [NUM_COLS-1:0]        col_hi_ref,
    output logic [2*NUM_COLS-1:0]      col_phase
);

    localparam int PH_W = 2;

    logic   copy_pulse;
    phase_t phase;

    // Strobe synchronizer and falling-edge detector.
    lcs_strobe_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_async(ld_strobe),
        .copy_pulse  (copy_pulse)
    );

    // Common charge-share / drive sequencer.
    lcs_share_timer #(
        .LEN_W(LEN_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .copy_pulse(copy_pulse),
        .share_len (share_len),
        .phase     (phase)
    );

    // One holding lane per column; parity picks the reference mapping.
    for (genvar i = 0; i < NUM_COLS; i++) begin : g_lane
        localparam bit IS_ODD = (i % 2) == 1;
        lcs_column_lane #(
            .GRAY_W (GRAY_W),
            .ODD_COL(IS_ODD)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .copy_pulse(copy_pulse),
            .pol_sel   (pol_sel),
            .code_in   (line_codes[i*GRAY_W +: GRAY_W]),
            .phase_in  (phase),
            .code_out  (col_codes[i*GRAY_W +: GRAY_W]),
            .hi_ref    (col_hi_ref[i]),
            .phase_out (col_phase[i*PH_W +: PH_W])
        );
    end

endmodule

// File: rtl/lcs_line_latch_chk.sv
// Property checker for lcs_line_latch, attached by bind. It observes the
// ports and the copy pulse that the synchronizer hands to the lanes.
module lcs_line_latch_chk #(
    parameter int NUM_COLS = 384,
    parameter int GRAY_W   = 6,
    parameter int LEN_W    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ld_strobe,
    input logic [LEN_W-1:0]           share_len,
    input logic                       copy_pulse,
    input logic [NUM_COLS*GRAY_W-1:0] col_codes,
    input logic [NUM_COLS-1:0]        col_hi_ref,
    input logic [1:0]                 phase0
);

    // R2: a copy only follows a strobe seen low two edges earlier.
    a_r2_copy_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        copy_pulse |-> !$past(ld_strobe, 2));

    // R3: a non-zero length starts a share phase.
    a_r3_share_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_pulse && share_len != '0) |=> phase0 == 2'b01);

    // R3: once active the phase never returns to idle.
    a_r3_no_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
        (phase0 != 2'b00) |=> (phase0 != 2'b00));

    // R3: drive persists until a new copy.
    a_r3_drive_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_pulse && phase0 == 2'b10) |=> phase0 == 2'b10);

    // R4: zero length goes straight to drive.
    a_r4_zero_share: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_pulse && share_len == '0) |=> phase0 == 2'b10);

    // R5: neighbouring columns use opposite reference sets.
    a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (col_hi_ref[NUM_COLS-1:1] ^ col_hi_ref[NUM_COLS-2:0]) == '1);

    // R6: reference selects hold between copies.
    a_r6_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_pulse |=> $stable(col_hi_ref));

    // R7: held codes hold between copies.
    a_r7_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_pulse |=> $stable(col_codes));

endmodule

bind lcs_line_latch lcs_line_latch_chk #(
    .NUM_COLS(NUM_COLS),
    .GRAY_W  (GRAY_W),
    .LEN_W   (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_strobe (ld_strobe),
    .share_len (share_len),
    .copy_pulse(copy_pulse),
    .col_codes (col_codes),
    .col_hi_ref(col_hi_ref),
    .phase0    (col_phase[1:0])
);

// File: tb/sim_lcs_line_latch.sv
`timescale 1ns/1ps
module sim_lcs_line_latch;

    localparam int NCOL = 8;
    localparam int GW   = 6;
    localparam int LW   = 8;
    localparam int VW   = NCOL * GW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_strobe = 1'b1;
    logic            pol_sel = 1'b0;
    logic [VW-1:0]   line_codes = '0;
    logic [LW-1:0]   share_len = '0;
    logic [VW-1:0]   col_codes;
    logic [NCOL-1:0] col_hi_ref;
    logic [2*NCOL-1:0] col_phase;

    int    tests = 0;
    int    fails = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    lcs_line_latch #(.NUM_COLS(NCOL), .GRAY_W(GW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .pol_sel(pol_sel),
        .line_codes(line_codes), .share_len(share_len),
        .col_codes(col_codes), .col_hi_ref(col_hi_ref), .col_phase(col_phase)
    );

    // Deterministic test line from a seed.
    function automatic logic [VW-1:0] mk_line(input int seed);
        logic [VW-1:0] v;
        for (int i = 0; i < NCOL; i++) v[i*GW +: GW] = GW'((seed * 7 + i * 13 + 5) & 63);
        return v;
    endfunction

    function automatic logic [NCOL-1:0] ref_pattern(input bit p);
        logic [NCOL-1:0] v;
        for (int i = 0; i < NCOL; i++) v[i] = p ^ (i % 2 == 1);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---- behavioural reference model ----
    logic [VW-1:0] m_codes;
    bit            m_pol;
    int            m_phase;   // 0 idle, 1 share, 2 drive
    int            m_cnt;
    bit            h1, h2, h3; // strobe samples at the last three edges

    always @(posedge clk) begin
        if (!rst_n) begin
            m_codes = '0; m_pol = 1'b0; m_phase = 0; m_cnt = 0;
            h1 = 1'b1; h2 = 1'b1; h3 = 1'b1;
        end else begin
            if (h3 && !h2) begin
                m_codes = line_codes; m_pol = pol_sel; m_cnt = int'(share_len);
                m_phase = (m_cnt == 0) ? 2 : 1;
            end else if (m_phase == 1) begin
                if (m_cnt == 1) m_phase = 2;
                m_cnt--;
            end
            h3 = h2; h2 = h1; h1 = ld_strobe;
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            logic [2*NCOL-1:0] ep;
            for (int i = 0; i < NCOL; i++) ep[2*i +: 2] = 2'(m_phase);
            chk(col_codes === m_codes, {cur_req, " codes"}, longint'(col_codes), longint'(m_codes));
            chk(col_hi_ref === ref_pattern(m_pol), {cur_req, " hi_ref"},
                longint'(col_hi_ref), longint'(ref_pattern(m_pol)));
            chk(col_phase === ep, {cur_req, " phase"}, longint'(col_phase), longint'(ep));
        end
    end

    // Drop the strobe and return at the negedge just after the copy edge.
    task automatic drop_and_copy();
        @(negedge clk); ld_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_share(output int n);
        n = 0;
        while (col_phase[1:0] == 2'b01 && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        line_codes = mk_line(1); share_len = 8'd4;
        @(posedge clk); cmp_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(col_phase == '0, "R1 phase idle", longint'(col_phase), 0);
        chk(col_codes == '0, "R1 codes zero", longint'(col_codes), 0);
        chk(col_hi_ref == ref_pattern(1'b0), "R1 ref pattern", longint'(col_hi_ref),
            longint'(ref_pattern(1'b0)));

        // R2: copy lands on the third edge seeing the strobe low
        cur_req = "R2";
        line_codes = mk_line(2);
        @(negedge clk); ld_strobe = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(col_codes == '0, "R2 not yet copied", longint'(col_codes), 0);
        @(posedge clk); @(negedge clk);
        chk(col_codes == mk_line(2), "R2 copied", longint'(col_codes), longint'(mk_line(2)));

        // R3: share lasts exactly share_len cycles then drive
        cur_req = "R3";
        count_share(n);
        chk(n == 4, "R3 share cycles", n, 4);
        chk(col_phase[1:0] == 2'b10, "R3 drive after share", col_phase[1:0], 2);
        ld_strobe = 1'b1;

        // R9: rising edge alone does nothing
        cur_req = "R9";
        repeat (6) @(negedge clk);
        chk(col_codes == mk_line(2) && col_phase[1:0] == 2'b10, "R9 rise ignored",
            longint'(col_codes), longint'(mk_line(2)));

        // R4: zero share length
        cur_req = "R4";
        share_len = 8'd0; line_codes = mk_line(3);
        drop_and_copy();
        chk(col_phase[1:0] == 2'b10, "R4 direct drive", col_phase[1:0], 2);
        repeat (3) @(negedge clk); ld_strobe = 1'b1;
        repeat (4) @(negedge clk);

        // R5: polarity high swaps the mapping
        cur_req = "R5";
        share_len = 8'd2; pol_sel = 1'b1; line_codes = mk_line(4);
        drop_and_copy();
        chk(col_hi_ref == ref_pattern(1'b1), "R5 pol high", longint'(col_hi_ref),
            longint'(ref_pattern(1'b1)));

        // R6 / R7: later input changes are ignored
        cur_req = "R6";
        pol_sel = 1'b0;
        line_codes = mk_line(5);
        repeat (3) @(negedge clk); ld_strobe = 1'b1;
        repeat (5) @(negedge clk);
        chk(col_hi_ref == ref_pattern(1'b1), "R6 pol held", longint'(col_hi_ref),
            longint'(ref_pattern(1'b1)));
        cur_req = "R7";
        chk(col_codes == mk_line(4), "R7 codes held", longint'(col_codes), longint'(mk_line(4)));

        // R5: back to polarity low
        cur_req = "R5";
        drop_and_copy();
        chk(col_hi_ref == ref_pattern(1'b0), "R5 pol low", longint'(col_hi_ref),
            longint'(ref_pattern(1'b0)));
        repeat (3) @(negedge clk); ld_strobe = 1'b1;
        repeat (5) @(negedge clk);

        // R8: retrigger during share restarts with new data and length
        cur_req = "R8";
        share_len = 8'd10; line_codes = mk_line(6);
        drop_and_copy();
        repeat (2) @(negedge clk); ld_strobe = 1'b1;
        share_len = 8'd3; line_codes = mk_line(7);
        drop_and_copy();
        count_share(n);
        chk(n == 3, "R8 restarted share", n, 3);
        chk(col_codes == mk_line(7), "R8 new codes", longint'(col_codes), longint'(mk_line(7)));
        ld_strobe = 1'b1;
        repeat (5) @(negedge clk);

        // R10: share length captured at copy
        cur_req = "R10";
        share_len = 8'd6; line_codes = mk_line(8);
        drop_and_copy();
        share_len = 8'd1;
        count_share(n);
        chk(n == 6, "R10 length held", n, 6);
        ld_strobe = 1'b1;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule